// File: doc/BRIEF.md
# Packed halfword extend, saturate and pack unit

This combinational datapath treats a 32-bit word as two 16-bit lanes and performs one of several repacking operations in the same cycle that its inputs change. An opcode chooses the operation. It can clamp each lane to a programmable signed or unsigned range. It can take two bytes of a rotated word and widen each one to a halfword, either on its own or with each widened value added to a halfword of a second operand. It can also merge one half of each of two operands, where one of them is shifted first.

The result comes with a two-bit flag that marks which lanes a saturation actually clamped. The block holds no state. The surrounding pipeline registers its outputs and supplies the opcode and the width or shift amount.

Top module: `hwpk_unit`

## Requirements
- R1: Opcode 0 clamps each halfword of `opnd_a`, read as signed, to the range -2^w .. 2^w-1. Here w is `amt[3:0]`, so the saturated width n is w+1 (1..16). For example, 0x80030168 with w=7 gives 0xFF80007F.
- R2: Opcode 1 clamps each signed halfword of `opnd_a` to the range 0 .. 2^w-1, with w = `amt[3:0]` (0..15). Negative lanes become 0, and a lane of 0x0168 with w=8 becomes 0x00FF.
- R3: `lane_clip[0]` refers to the low halfword and `lane_clip[1]` to the high halfword. Under opcodes 0 and 1, each bit is 1 exactly when its lane was changed by clamping. Under every other opcode both bits are 0.
- R4: Opcode 2 rotates `opnd_b` right by 8*`byte_rot` bits. It then sign-extends byte 0 of the rotated word into the low halfword and byte 2 into the high halfword. For example, 0x80830168 gives 0xFF830068 with rotate 0, 0xFF800001 with rotate 1, and 0x0001FF80 with rotate 3.
- R5: Opcode 3 does the same byte selection as opcode 2 but zero-extends, so 0x80830168 with rotate 0 gives 0x00830068.
- R6: Opcodes 4 (signed) and 5 (unsigned) add each extended halfword to the matching halfword of `opnd_a`, modulo 2^16 per lane, with no carry from the low lane into the high lane. For example, 0x000D0008 plus the signed extension of 0x80830168 gives 0xFF900070.
- R7: Opcode 6 returns the low halfword of `opnd_a` in bits 15:0, and bits 31:16 of `opnd_b` shifted left by `amt` (0..31) in bits 31:16. For example, 0x00000111 and 0x22200000 with shift 4 give 0x22000111.
- R8: Opcode 7 returns the high halfword of `opnd_a` in bits 31:16, and bits 15:0 of `opnd_b` shifted right arithmetically by `amt` (0..31) in bits 15:0. For example, 0x11100000 and 0x00000222 with shift 4 give 0x11100022.
- R9: Opcodes 8 to 15 drive `result` to zero and both `lane_clip` bits to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | Saturation source, addend, or kept half for packing |
| opnd_b | input | 32 | Extension source or shifted half for packing |
| byte_rot | input | 2 | Right rotation of `opnd_b` in bytes before extension |
| amt | input | 5 | Width code in bits 3:0 for saturation; shift 0..31 for packing |
| result | output | 32 | Repacked word |
| lane_clip | output | 2 | Per-lane clamp-occurred flags |

## Verification
Byte rotation and the lane-wise add take effect in the same evaluation of the extend-and-add operations. A wrong rotation or a carry leaking between lanes would only show when both are exercised together. The sweep runs every rotation with addends whose low lane is near 0xFFFF, so that the low sum wraps. It judges the high lane against a reference that picks bytes by index arithmetic and reduces each lane sum modulo 2^16 on its own. Saturation clamping and its lane flags are also judged together in every vector, at each width, with values just inside and just outside each bound.

// File: rtl/hwpk_pkg.sv
`timescale 1ns/1ps
package hwpk_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = 8;
  localparam int LANES  = WORD_W / HALF_W;
  localparam int WCODE_W = $clog2(HALF_W);
  localparam int SHIFT_W = $clog2(WORD_W);

  typedef enum logic [3:0] {
    OPC_SAT_S  = 4'd0,
    OPC_SAT_U  = 4'd1,
    OPC_EXT_S  = 4'd2,
    OPC_EXT_U  = 4'd3,
    OPC_EXTA_S = 4'd4,
    OPC_EXTA_U = 4'd5,
    OPC_PK_LO  = 4'd6,
    OPC_PK_HI  = 4'd7
  } hwpk_op_e;

  typedef struct packed {
    logic              clip;
    logic [HALF_W-1:0] val;
  } sat_res_t;

  // Clamp one signed halfword; signed range is -2^w..2^w-1, unsigned 0..2^w-1.
  function automatic sat_res_t sat_half(input logic [HALF_W-1:0] x,
                                        input logic [WCODE_W-1:0] wc,
                                        input logic sgn);
    sat_res_t s;
    int v, hi, lo;
    v  = int'(signed'(x));
    hi = (1 << wc) - 1;
    lo = sgn ? -(1 << wc) : 0;
    s.clip = 1'b0;
    if (v > hi) begin
      v = hi;
      s.clip = 1'b1;
    end else if (v < lo) begin
      v = lo;
      s.clip = 1'b1;
    end
    s.val = v[HALF_W-1:0];
    return s;
  endfunction

  // Rotate right by whole bytes, widen bytes 0 and 2, optionally add lane-wise.
  function automatic logic [WORD_W-1:0] ext_pair(input logic [WORD_W-1:0] src,
                                                 input logic [1:0] rot,
                                                 input logic sgn,
                                                 input logic [WORD_W-1:0] addend,
                                                 input logic add);
    logic [2*WORD_W-1:0] dbl;
    logic [WORD_W-1:0]   r;
    logic [HALF_W-1:0]   lo, hi;
    dbl = {src, src};
    r   = dbl[{rot, 3'b000} +: WORD_W];
    lo  = sgn ? {{(HALF_W-BYTE_W){r[BYTE_W-1]}}, r[BYTE_W-1:0]}
              : {{(HALF_W-BYTE_W){1'b0}}, r[BYTE_W-1:0]};
    hi  = sgn ? {{(HALF_W-BYTE_W){r[HALF_W+BYTE_W-1]}}, r[HALF_W +: BYTE_W]}
              : {{(HALF_W-BYTE_W){1'b0}}, r[HALF_W +: BYTE_W]};
    if (add) begin
      lo = lo + addend[HALF_W-1:0];
      hi = hi + addend[WORD_W-1:HALF_W];
    end
    return {hi, lo};
  endfunction

  // Keep one half of a, fill the other from shifted b.
  function automatic logic [WORD_W-1:0] pack_pair(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b,
                                                  input logic [SHIFT_W-1:0] sh,
                                                  input logic keep_top);
    logic [WORD_W-1:0]        sl;
    logic signed [WORD_W-1:0] sr;
    sl = b << sh;
    sr = $signed(b) >>> sh;
    return keep_top ? {a[WORD_W-1:HALF_W], sr[HALF_W-1:0]}
                    : {sl[WORD_W-1:HALF_W], a[HALF_W-1:0]};
  endfunction
endpackage

// File: rtl/hwpk_lane_sat.sv
`timescale 1ns/1ps
module hwpk_lane_sat
  import hwpk_pkg::*;
(
  input  logic [HALF_W-1:0]  lane_in,
  input  logic [WCODE_W-1:0] wcode,
  input  logic               is_signed,
  output logic [HALF_W-1:0]  lane_out,
  output logic               clip
);
  sat_res_t s;

  always_comb begin
    s        = sat_half(lane_in, wcode, is_signed);
    lane_out = s.val;
    clip     = s.clip;
  end

  logic [HALF_W-1:0] upper_u;
  logic [HALF_W-1:0] upper_s;
  always_comb begin
    upper_u = lane_out >> wcode;
    upper_s = $signed(lane_out) >>> wcode;
  end

  always_comb begin
    // R3
    unclipped_passes_chk: assert (clip || (lane_out == lane_in));
    // R2
    if (!is_signed) begin
      urange_fit_chk: assert (upper_u == '0);
    end
    // R1
    if (is_signed) begin
      srange_fit_chk: assert ((upper_s == '0) || (upper_s == '1));
    end
  end
endmodule

// File: rtl/hwpk_byte_ext.sv
`timescale 1ns/1ps
module hwpk_byte_ext
  import hwpk_pkg::*;
(
  input  logic [WORD_W-1:0] src,
  input  logic [WORD_W-1:0] addend,
  input  logic [1:0]        rot,
  input  logic              sign_ext,
  input  logic              add_en,
  output logic [WORD_W-1:0] ext_out
);
  always_comb ext_out = ext_pair(src, rot, sign_ext, addend, add_en);

  always_comb begin
    if (!add_en && !sign_ext) begin
      // R5
      zext_upper_chk: assert ((ext_out[HALF_W-1:BYTE_W] == '0) &&
                              (ext_out[WORD_W-1:HALF_W+BYTE_W] == '0));
    end
    if (!add_en && sign_ext) begin
      // R4
      sext_upper_chk: assert ((ext_out[HALF_W-1:BYTE_W] == {(HALF_W-BYTE_W){ext_out[BYTE_W-1]}}) &&
                              (ext_out[WORD_W-1:HALF_W+BYTE_W] ==
                               {(HALF_W-BYTE_W){ext_out[HALF_W+BYTE_W-1]}}));
    end
  end
endmodule

// File: rtl/hwpk_half_pack.sv
`timescale 1ns/1ps
module hwpk_half_pack
  import hwpk_pkg::*;
(
  input  logic [WORD_W-1:0]  a,
  input  logic [WORD_W-1:0]  b,
  input  logic [SHIFT_W-1:0] sh,
  input  logic               keep_top,
  output logic [WORD_W-1:0]  packed_out
);
  always_comb packed_out = pack_pair(a, b, sh, keep_top);

  always_comb begin
    // R7
    if (!keep_top) begin
      keep_low_chk: assert (packed_out[HALF_W-1:0] == a[HALF_W-1:0]);
    end
    // R8
    if (keep_top) begin
      keep_high_chk: assert (packed_out[WORD_W-1:HALF_W] == a[WORD_W-1:HALF_W]);
    end
  end
endmodule

// File: rtl/hwpk_unit.sv
`timescale 1ns/1ps
module hwpk_unit
  import hwpk_pkg::*;
(
  input  logic [3:0]  op_sel,
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [1:0]  byte_rot,
  input  logic [4:0]  amt,
  output logic [31:0] result,
  output logic [1:0]  lane_clip
);
  logic               sat_signed;
  logic               is_sat_op;
  logic               ext_sgn;
  logic               ext_add;
  logic               pk_top;
  logic [WORD_W-1:0]  sat_word;
  logic [LANES-1:0]   sat_clip;
  logic [WORD_W-1:0]  ext_word;
  logic [WORD_W-1:0]  pack_word;

  always_comb begin
    sat_signed = (op_sel == OPC_SAT_S);
    is_sat_op  = (op_sel == OPC_SAT_S) || (op_sel == OPC_SAT_U);
    ext_sgn    = (op_sel == OPC_EXT_S) || (op_sel == OPC_EXTA_S);
    ext_add    = (op_sel == OPC_EXTA_S) || (op_sel == OPC_EXTA_U);
    pk_top     = (op_sel == OPC_PK_HI);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hwpk_lane_sat u_sat (
      .lane_in  (opnd_a[g*HALF_W +: HALF_W]),
      .wcode    (amt[WCODE_W-1:0]),
      .is_signed(sat_signed),
      .lane_out (sat_word[g*HALF_W +: HALF_W]),
      .clip     (sat_clip[g])
    );
  end

  hwpk_byte_ext u_ext (
    .src     (opnd_b),
    .addend  (opnd_a),
    .rot     (byte_rot),
    .sign_ext(ext_sgn),
    .add_en  (ext_add),
    .ext_out (ext_word)
  );

  hwpk_half_pack u_pack (
    .a         (opnd_a),
    .b         (opnd_b),
    .sh        (amt[SHIFT_W-1:0]),
    .keep_top  (pk_top),
    .packed_out(pack_word)
  );

  always_comb begin
    result    = '0;
    lane_clip = '0;
    case (op_sel)
      OPC_SAT_S, OPC_SAT_U: begin
        result    = sat_word;
        lane_clip = sat_clip;
      end
      OPC_EXT_S, OPC_EXT_U, OPC_EXTA_S, OPC_EXTA_U: result = ext_word;
      OPC_PK_LO, OPC_PK_HI: result = pack_word;
      default: begin
        result    = '0;
        lane_clip = '0;
      end
    endcase
  end

  always_comb begin
    // R3
    if (!is_sat_op) begin
      flag_quiet_chk: assert (lane_clip == '0);
    end
    // R9
    if (op_sel[3]) begin
      unused_zero_chk: assert ((result == '0) && (lane_clip == '0));
    end
  end
endmodule

// File: tb/sim_hwpk_unit.sv
`timescale 1ns/1ps
module sim_hwpk_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [1:0]  byte_rot = '0;
  logic [4:0]  amt = '0;
  logic [31:0] result;
  logic [1:0]  lane_clip;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hwpk_unit u0 (
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .byte_rot(byte_rot),
    .amt(amt), .result(result), .lane_clip(lane_clip)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] r, input logic [4:0] m);
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; byte_rot = r; amt = m;
    @(negedge clk);
  endtask

  // returns {clip, value}
  function automatic logic [16:0] ref_sat(input logic [15:0] x, input int w, input bit sg);
    longint v, top, bot;
    logic [15:0] o;
    v = (x >= 16'h8000) ? longint'(x) - 65536 : longint'(x);
    top = 2**w - 1;
    bot = sg ? -(2**w) : 0;
    if (v > top) return {1'b1, 16'(top)};
    if (v < bot) begin
      o = 16'(bot + 65536);
      return {1'b1, o};
    end
    return {1'b0, x};
  endfunction

  function automatic logic [15:0] ref_widen(input logic [7:0] by, input bit sg);
    return (sg && by >= 8'h80) ? (16'hFF00 + 16'(by)) : 16'(by);
  endfunction

  function automatic logic [31:0] ref_ext(input logic [31:0] b, input int r, input bit sg,
                                          input logic [31:0] a, input bit ad);
    logic [7:0] b0, b2;
    longint lo, hi;
    b0 = b[8*((r + 0) % 4) +: 8];
    b2 = b[8*((r + 2) % 4) +: 8];
    lo = longint'(ref_widen(b0, sg));
    hi = longint'(ref_widen(b2, sg));
    if (ad) begin
      lo = (lo + longint'(a[15:0])) % 65536;
      hi = (hi + longint'(a[31:16])) % 65536;
    end
    return {16'(hi), 16'(lo)};
  endfunction

  function automatic logic [31:0] ref_pack(input logic [31:0] a, input logic [31:0] b,
                                           input int sh, input bit top);
    longint v, q;
    if (!top) begin
      v = (longint'(b) * (2**sh)) % (2**32);
      return {16'(v / 65536), a[15:0]};
    end
    v = (b[31]) ? longint'(b) - 2**32 : longint'(b);
    q = (v >= 0) ? v / (2**sh) : -((-v + 2**sh - 1) / (2**sh));
    return {a[31:16], 16'(q % 65536 + ((q % 65536) < 0 ? 65536 : 0))};
  endfunction

  task automatic sat_case(input logic [15:0] hi_l, input logic [15:0] lo_l, input int w, input bit sg);
    logic [16:0] eh, el;
    eh = ref_sat(hi_l, w, sg);
    el = ref_sat(lo_l, w, sg);
    apply(sg ? 4'd0 : 4'd1, {hi_l, lo_l}, 32'h5A5A_A5A5, 2'd3, 5'(w));
    if (sg) chk("R1 signed sat value", result, {eh[15:0], el[15:0]});
    else    chk("R2 unsigned sat value", result, {eh[15:0], el[15:0]});
    chk("R3 clip flags", {30'd0, lane_clip}, {30'd0, eh[16], el[16]});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset-time result", result, 32'h0);
    chk("R3 reset-time flags", {30'd0, lane_clip}, 32'h0);
    rst = 1'b0;

    // stated examples
    apply(4'd0, 32'h80030168, 32'h0, 2'd0, 5'd7);
    chk("R1 example", result, 32'hFF80007F);
    chk("R3 example both clipped", {30'd0, lane_clip}, 32'h3);
    apply(4'd1, 32'h80030168, 32'h0, 2'd0, 5'd8);
    chk("R2 example", result, 32'h000000FF);
    apply(4'd2, 32'h0, 32'h80830168, 2'd0, 5'd0);
    chk("R4 example rot0", result, 32'hFF830068);
    apply(4'd2, 32'h0, 32'h80830168, 2'd1, 5'd0);
    chk("R4 example rot1", result, 32'hFF800001);
    apply(4'd2, 32'h0, 32'h80830168, 2'd3, 5'd0);
    chk("R4 example rot3", result, 32'h0001FF80);
    apply(4'd3, 32'h0, 32'h80830168, 2'd0, 5'd0);
    chk("R5 example", result, 32'h00830068);
    apply(4'd4, 32'h000D0008, 32'h80830168, 2'd0, 5'd0);
    chk("R6 example", result, 32'hFF900070);
    apply(4'd6, 32'h00000111, 32'h22200000, 2'd0, 5'd4);
    chk("R7 example", result, 32'h22000111);
    apply(4'd7, 32'h11100000, 32'h00000222, 2'd0, 5'd4);
    chk("R8 example", result, 32'h11100022);

    // saturation: bounds at every width, then a strided sweep
    for (int w = 0; w < 16; w++) begin
      for (int sg = 0; sg < 2; sg++) begin
        logic [15:0] top, bot;
        top = 16'((2**w) - 1);
        bot = sg ? 16'(65536 - 2**w) : 16'h0000;
        sat_case(top, bot, w, sg[0]);
        sat_case(top + 16'd1, bot - 16'd1, w, sg[0]);
        sat_case(16'h7FFF, 16'h8000, w, sg[0]);
        for (int x = 0; x < 65536; x += 97)
          sat_case(16'(x), 16'(x) ^ 16'h8001, w, sg[0]);
      end
    end

    // extension, with and without add, every rotation; low-lane addends near wrap
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 256; i++) begin
        logic [31:0] b, a;
        b = {8'(i), 8'(i) ^ 8'h5A, ~8'(i), 8'(i + 3)};
        a = {16'(i * 257), 16'hFFFF - 16'(i)};
        for (int op = 2; op < 6; op++) begin
          bit sg, ad;
          sg = (op == 2) || (op == 4);
          ad = (op >= 4);
          apply(4'(op), a, b, 2'(r), 5'(i));
          if (ad) chk("R6 extend-add lanes", result, ref_ext(b, r, sg, a, ad));
          else if (sg) chk("R4 sign extend", result, ref_ext(b, r, sg, a, ad));
          else chk("R5 zero extend", result, ref_ext(b, r, sg, a, ad));
          chk("R3 flags quiet", {30'd0, lane_clip}, 32'h0);
        end
      end
    end

    // packing, every shift amount
    for (int sh = 0; sh < 32; sh++) begin
      for (int p = 0; p < 6; p++) begin
        logic [31:0] a, b;
        a = 32'h1357_9BDF ^ (32'h0F0F_1111 * p);
        b = 32'h8765_4321 + (32'h1234_8765 * p);
        apply(4'd6, a, b, 2'd2, 5'(sh));
        chk("R7 pack low-keep", result, ref_pack(a, b, sh, 1'b0));
        apply(4'd7, a, b, 2'd1, 5'(sh));
        chk("R8 pack high-keep", result, ref_pack(a, b, sh, 1'b1));
      end
    end

    // unused opcodes
    for (int op = 8; op < 16; op++) begin
      apply(4'(op), 32'h8000_8000, 32'hFFFF_FFFF, 2'd3, 5'd0);
      chk("R9 unused result", result, 32'h0);
      chk("R9 unused flags", {30'd0, lane_clip}, 32'h0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule